// File: doc/BRIEF.md
# Per-Core Interrupt Router

This block gathers the interrupt sources that belong to each of four processor cores, plus one shared graphics interrupt, and turns them into an `irq` and a `fiq` line for every core. Each core has four timer sources and one performance-monitor source. The performance-monitor source is always delivered in the normal (IRQ) class. Each core also receives four mailbox pending levels, split by class, from a separate mailbox block. The graphics interrupt arrives on two wires, one per class, and each wire is steered to exactly one core.

Software configures the block through a small register space on a single-cycle write / combinational read bus. Per-core timer control registers hold an IRQ enable and a FIQ enable for each timer source. When both are set, the fast class wins. Performance-monitor delivery is controlled by a mask with separate set and clear strobes. A routing register chooses the target core for the graphics IRQ and, separately, for the graphics FIQ. Two read-only status words per core show what is pending in each class. Every source is treated as a level: status follows the inputs in the same cycle.

Top module: `ir_router`

## Requirements
- R1: After a synchronous active-low reset, every timer control register and the performance-monitor mask read 0, and the routing register reads 0. With routing at 0, both graphics classes go to core 0.
- R2: The timer control register of core c sits at 0x40+4c. Bits [7:0] are stored and read back: bits [3:0] are the IRQ enables of timers 0–3 and bits [7:4] are their FIQ enables. Bits above 7 read as 0.
- R3: A timer source that is high with only its IRQ enable set shows in bit t (t = 0..3) of that core's IRQ status word (0x60+4c) and not in its FIQ status word (0x70+4c).
- R4: A timer source that is high with its FIQ enable set shows in bit t of the FIQ status word and never in the IRQ status word, whatever its IRQ enable holds.
- R5: Writing to 0x10 sets the mask bits written as 1 (bit c = core c). Bits written as 0 leave their mask bits unchanged. Reads of 0x10 and 0x14 both return the mask.
- R6: Writing to 0x14 clears the mask bits written as 1. Bits written as 0 leave their mask bits unchanged.
- R7: Bit 9 of a core's IRQ status is high exactly when that core's performance-monitor source is high and its mask bit is set.
- R8: Routing register 0x0C: bits [1:0] select the core that receives the graphics IRQ, and bits [3:2] select the core that receives the graphics FIQ. The selected core shows the source in bit 8 of the matching status word, and no other core does.
- R9: Mailbox levels for core c, mailbox m, appear unchanged in bit 4+m of the core's IRQ or FIQ status word, according to the class of the input wire.
- R10: `core_irq[c]` is the OR of core c's IRQ status bits, and `core_fiq[c]` is the OR of its FIQ status bits.
- R11: Status bits follow the source levels with no latching. When a source drops, its status bit clears in the same cycle.
- R12: Writes to the status words at 0x60–0x7C have no effect on the status words or on any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| timer_src | input | 16 | Timer source levels, core c timer t at bit 4c+t |
| pmu_src | input | 4 | Performance-monitor level per core |
| gpu_irq_src | input | 1 | Shared graphics interrupt, normal class |
| gpu_fiq_src | input | 1 | Shared graphics interrupt, fast class |
| mbox_irq | input | 16 | Mailbox IRQ-class pending, core c mailbox m at bit 4c+m |
| mbox_fiq | input | 16 | Mailbox FIQ-class pending, same layout |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
Two things can land in the same cycle: a bus write that changes a timer's enables, and the evaluation of a source that is already high. The bench holds a timer source high and rewrites its control word from IRQ-only to FIQ-only. It then checks that the status moves from one class to the other on the write edge, and never shows in both classes. An assertion in the core slice guards this continuously. The same kind of overlap is provoked for the performance-monitor mask and the graphics routing while their sources are held high.

// File: rtl/ir_pkg.sv
// Package: shared constants of the interrupt router.
// Assumes four sources of each per-core kind; the register offsets below
// are fixed by the software view and do not scale with the parameters.
package ir_pkg;
    localparam int TIMERS  = 4;
    localparam int MBOXES  = 4;
    localparam int PEND_W  = TIMERS + MBOXES + 2;
    localparam int BIT_GPU = TIMERS + MBOXES;
    localparam int BIT_PMU = TIMERS + MBOXES + 1;
    localparam int CTRL_W  = 2 * TIMERS;

    localparam logic [7:0] OFS_ROUTE   = 8'h0C;
    localparam logic [7:0] OFS_PMU_SET = 8'h10;
    localparam logic [7:0] OFS_PMU_CLR = 8'h14;
    localparam logic [7:0] OFS_TMR     = 8'h40;
    localparam logic [7:0] OFS_IRQ_ST  = 8'h60;
    localparam logic [7:0] OFS_FIQ_ST  = 8'h70;
endpackage

// File: rtl/ir_cfg_regs.sv
// Module: configuration registers and read-back mux.
// Holds timer control words, performance-monitor mask and graphics routing.
// Assumes single-cycle writes and a combinational read of any address;
// status words arrive from the core slices and are read-only here.
module ir_cfg_regs
    import ir_pkg::*;
#(
    parameter int CORES  = 4,
    parameter int DATA_W = 32,
    parameter int SEL_W  = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [7:0]               addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [CORES*PEND_W-1:0]  irq_stat,
    input  logic [CORES*PEND_W-1:0]  fiq_stat,
    output logic [DATA_W-1:0]        rdata,
    output logic [CORES*CTRL_W-1:0]  tmr_ctrl,
    output logic [CORES-1:0]         pmu_mask,
    output logic [SEL_W-1:0]         gpu_irq_sel,
    output logic [SEL_W-1:0]         gpu_fiq_sel
);

    // Register update: route, mask set/clear and per-core timer control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_ctrl    <= '0;
            pmu_mask    <= '0;
            gpu_irq_sel <= '0;
            gpu_fiq_sel <= '0;
        end else if (wr) begin
            if (addr == OFS_ROUTE) begin
                gpu_irq_sel <= wdata[SEL_W-1:0];
                gpu_fiq_sel <= wdata[2*SEL_W-1:SEL_W];
            end
            if (addr == OFS_PMU_SET) pmu_mask <= pmu_mask | wdata[CORES-1:0];
            if (addr == OFS_PMU_CLR) pmu_mask <= pmu_mask & ~wdata[CORES-1:0];
            for (int c = 0; c < CORES; c++) begin
                if (addr == OFS_TMR + 8'(4 * c))
                    tmr_ctrl[c*CTRL_W +: CTRL_W] <= wdata[CTRL_W-1:0];
            end
        end
    end

    // Read-back mux over every readable address; unmapped reads give 0.
    always_comb begin
        rdata = '0;
        if (addr == OFS_ROUTE)
            rdata = DATA_W'({gpu_fiq_sel, gpu_irq_sel});
        if (addr == OFS_PMU_SET || addr == OFS_PMU_CLR)
            rdata = DATA_W'(pmu_mask);
        for (int c = 0; c < CORES; c++) begin
            if (addr == OFS_TMR + 8'(4 * c))
                rdata = DATA_W'(tmr_ctrl[c*CTRL_W +: CTRL_W]);
            if (addr == OFS_IRQ_ST + 8'(4 * c))
                rdata = DATA_W'(irq_stat[c*PEND_W +: PEND_W]);
            if (addr == OFS_FIQ_ST + 8'(4 * c))
                rdata = DATA_W'(fiq_stat[c*PEND_W +: PEND_W]);
        end
    end

    // R1: reset leaves every enable and routing field at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (tmr_ctrl == '0 && pmu_mask == '0 &&
                    gpu_irq_sel == '0 && gpu_fiq_sel == '0));

    // R5: a set strobe leaves every written 1 set in the mask
    assert_pmu_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_PMU_SET) |=>
            ((pmu_mask & $past(wdata[CORES-1:0])) == $past(wdata[CORES-1:0])));

    // R6: a clear strobe removes every written 1 and keeps the rest
    assert_pmu_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_PMU_CLR) |=>
            (pmu_mask == ($past(pmu_mask) & ~$past(wdata[CORES-1:0]))));

    // R12: writes into the status window leave all configuration unchanged
    assert_status_ro_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr >= OFS_IRQ_ST && addr < OFS_FIQ_ST + 8'(4 * CORES)) |=>
            ($stable(tmr_ctrl) && $stable(pmu_mask) &&
             $stable(gpu_irq_sel) && $stable(gpu_fiq_sel)));

endmodule

// File: rtl/ir_core_slice.sv
// Module: status composition for one core.
// Builds the IRQ and FIQ status words from level sources and enables, and
// drives the core's two lines. Assumes graphics and monitor sources arrive
// already gated by routing and mask; mailbox levels are already classed.
module ir_core_slice
    import ir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIMERS-1:0] tmr_src,
    input  logic [CTRL_W-1:0] tmr_ctrl,
    input  logic [MBOXES-1:0] mbox_irq,
    input  logic [MBOXES-1:0] mbox_fiq,
    input  logic              gpu_irq_hit,
    input  logic              gpu_fiq_hit,
    input  logic              pmu_hit,
    output logic [PEND_W-1:0] irq_stat,
    output logic [PEND_W-1:0] fiq_stat,
    output logic              irq_line,
    output logic              fiq_line
);

    logic [TIMERS-1:0] irq_en;
    logic [TIMERS-1:0] fiq_en;
    logic [TIMERS-1:0] tmr_irq;
    logic [TIMERS-1:0] tmr_fiq;

    assign irq_en = tmr_ctrl[TIMERS-1:0];
    assign fiq_en = tmr_ctrl[CTRL_W-1:TIMERS];

    // Per-timer class choice: a fast enable takes the source away from IRQ.
    for (genvar t = 0; t < TIMERS; t++) begin : g_tmr
        assign tmr_fiq[t] = tmr_src[t] & fiq_en[t];
        assign tmr_irq[t] = tmr_src[t] & irq_en[t] & ~fiq_en[t];
    end

    // Status words in the fixed bit layout: timers, mailboxes, graphics, monitor.
    always_comb begin
        irq_stat = {pmu_hit, gpu_irq_hit, mbox_irq, tmr_irq};
        fiq_stat = {1'b0,    gpu_fiq_hit, mbox_fiq, tmr_fiq};
    end

    // Core lines: any pending bit of a class raises that class's line.
    assign irq_line = |irq_stat;
    assign fiq_line = |fiq_stat;

    // R4: no timer is ever pending in both classes
    assert_fiq_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat[TIMERS-1:0] & fiq_stat[TIMERS-1:0]) == '0);

    // R11: a low timer source has no status bit in either class
    assert_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_stat[TIMERS-1:0] | fiq_stat[TIMERS-1:0]) & ~tmr_src) == '0);

endmodule

// File: rtl/ir_router.sv
// Module: top of the per-core interrupt router.
// Instantiates the register block and one status slice per core, and steers
// the shared graphics lines and masked monitor sources into the slices.
// Assumes all sources are synchronous levels in the clk domain.
module ir_router
    import ir_pkg::*;
#(
    parameter int CORES  = 4,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [7:0]               bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [CORES*TIMERS-1:0]  timer_src,
    input  logic [CORES-1:0]         pmu_src,
    input  logic                     gpu_irq_src,
    input  logic                     gpu_fiq_src,
    input  logic [CORES*MBOXES-1:0]  mbox_irq,
    input  logic [CORES*MBOXES-1:0]  mbox_fiq,
    output logic [CORES-1:0]         core_irq,
    output logic [CORES-1:0]         core_fiq
);

    localparam int SEL_W = (CORES > 1) ? $clog2(CORES) : 1;

    logic [CORES*PEND_W-1:0] irq_stat;
    logic [CORES*PEND_W-1:0] fiq_stat;
    logic [CORES*CTRL_W-1:0] tmr_ctrl;
    logic [CORES-1:0]        pmu_mask;
    logic [SEL_W-1:0]        gpu_irq_sel;
    logic [SEL_W-1:0]        gpu_fiq_sel;
    logic [CORES-1:0]        gpu_irq_col;
    logic [CORES-1:0]        pmu_col;

    ir_cfg_regs #(
        .CORES  (CORES),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .irq_stat    (irq_stat),
        .fiq_stat    (fiq_stat),
        .rdata       (bus_rdata),
        .tmr_ctrl    (tmr_ctrl),
        .pmu_mask    (pmu_mask),
        .gpu_irq_sel (gpu_irq_sel),
        .gpu_fiq_sel (gpu_fiq_sel)
    );

    // One slice per core; graphics lines go only to the selected core.
    for (genvar c = 0; c < CORES; c++) begin : g_core
        ir_core_slice i_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .tmr_src     (timer_src[c*TIMERS +: TIMERS]),
            .tmr_ctrl    (tmr_ctrl[c*CTRL_W +: CTRL_W]),
            .mbox_irq    (mbox_irq[c*MBOXES +: MBOXES]),
            .mbox_fiq    (mbox_fiq[c*MBOXES +: MBOXES]),
            .gpu_irq_hit (gpu_irq_src && (gpu_irq_sel == SEL_W'(c))),
            .gpu_fiq_hit (gpu_fiq_src && (gpu_fiq_sel == SEL_W'(c))),
            .pmu_hit     (pmu_src[c] & pmu_mask[c]),
            .irq_stat    (irq_stat[c*PEND_W +: PEND_W]),
            .fiq_stat    (fiq_stat[c*PEND_W +: PEND_W]),
            .irq_line    (core_irq[c]),
            .fiq_line    (core_fiq[c])
        );
        assign gpu_irq_col[c] = irq_stat[c*PEND_W + BIT_GPU];
        assign pmu_col[c]     = irq_stat[c*PEND_W + BIT_PMU];
    end

    // R8: a high graphics IRQ lands on exactly one core
    assert_gpu_one_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gpu_irq_src |-> ($countones(gpu_irq_col) == 1));

    // R8: with the source low no core reports it
    assert_gpu_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gpu_irq_src |-> $onehot0(gpu_irq_col) && gpu_irq_col == '0);

    // R7: monitor status never appears on a core whose mask bit is clear
    assert_pmu_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pmu_col & ~pmu_mask) == '0);

endmodule

// File: tb/test_ir_router.sv
module test_ir_router;
    localparam int CORES = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] timer_src;
    logic [3:0]  pmu_src;
    logic        gpu_irq_src;
    logic        gpu_fiq_src;
    logic [15:0] mbox_irq;
    logic [15:0] mbox_fiq;
    logic [3:0]  core_irq;
    logic [3:0]  core_fiq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ir_router i_ir_router (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_src(timer_src),
        .pmu_src(pmu_src), .gpu_irq_src(gpu_irq_src), .gpu_fiq_src(gpu_fiq_src),
        .mbox_irq(mbox_irq), .mbox_fiq(mbox_fiq),
        .core_irq(core_irq), .core_fiq(core_fiq)
    );

    // Vector: {ctrl[7:0], src[3:0], exp_irq[3:0], exp_fiq[3:0]}
    localparam logic [19:0] VEC [8] = '{
        {8'h00, 4'hF, 4'h0, 4'h0},
        {8'h0F, 4'hF, 4'hF, 4'h0},
        {8'hF0, 4'hF, 4'h0, 4'hF},
        {8'hFF, 4'hF, 4'h0, 4'hF},
        {8'h33, 4'h5, 4'h0, 4'h1},
        {8'h5A, 4'hF, 4'hA, 4'h5},
        {8'hC3, 4'h6, 4'h2, 4'h4},
        {8'h0F, 4'h0, 4'h0, 4'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        timer_src = '0; pmu_src = '0; gpu_irq_src = 1'b0; gpu_fiq_src = 1'b0;
        mbox_irq = '0; mbox_fiq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h40, d); check("R1 timer ctrl core0", d, 0);
        rd(8'h4C, d); check("R1 timer ctrl core3", d, 0);
        rd(8'h10, d); check("R1 monitor mask", d, 0);
        rd(8'h0C, d); check("R1 routing", d, 0);
        gpu_irq_src = 1'b1; gpu_fiq_src = 1'b1;
        rd(8'h60, d); check("R1 graphics IRQ to core0", d, 32'h100);
        rd(8'h70, d); check("R1 graphics FIQ to core0", d, 32'h100);
        check("R10 lines after reset", {24'd0, core_fiq, core_irq}, 32'h11);
        gpu_irq_src = 1'b0; gpu_fiq_src = 1'b0;

        // R2 R3 R4: vector table over timer control and sources
        for (int i = 0; i < 8; i++) begin
            int c;
            logic [7:0] a;
            c = i % CORES;
            a = 8'h40 + 8'(4 * c);
            wr(a, {24'hFFFFFF, VEC[i][19:12]});
            timer_src = '0;
            timer_src[c*4 +: 4] = VEC[i][11:8];
            rd(a, d); check("R2 timer ctrl readback", d, {24'd0, VEC[i][19:12]});
            rd(8'h60 + 8'(4 * c), d); check("R3 timer IRQ status", d, {28'd0, VEC[i][7:4]});
            rd(8'h70 + 8'(4 * c), d); check("R4 timer FIQ status", d, {28'd0, VEC[i][3:0]});
            check("R10 IRQ line", {31'd0, core_irq[c]}, {31'd0, |VEC[i][7:4]});
            check("R10 FIQ line", {31'd0, core_fiq[c]}, {31'd0, |VEC[i][3:0]});
            wr(a, 32'h0);
        end
        timer_src = '0;

        // R4: switch class while source high, same-cycle overlap
        timer_src[4] = 1'b1;
        wr(8'h44, 32'h01);
        rd(8'h64, d); check("R3 core1 IRQ before switch", d, 32'h1);
        wr(8'h44, 32'h11);
        rd(8'h64, d); check("R4 core1 IRQ after switch", d, 32'h0);
        rd(8'h74, d); check("R4 core1 FIQ after switch", d, 32'h1);
        // R11: drop source, status clears
        timer_src[4] = 1'b0;
        #1 check("R11 FIQ line follows level", {31'd0, core_fiq[1]}, 32'h0);
        rd(8'h74, d); check("R11 status follows level", d, 32'h0);
        wr(8'h44, 32'h0);

        // R5 R6 R7: monitor mask
        pmu_src = 4'hF;
        wr(8'h10, 32'h5);
        rd(8'h10, d); check("R5 mask via set", d, 32'h5);
        rd(8'h14, d); check("R5 mask via clear", d, 32'h5);
        rd(8'h68, d); check("R7 core2 monitor pending", d, 32'h200);
        rd(8'h64, d); check("R7 core1 masked", d, 32'h0);
        wr(8'h10, 32'h0);
        rd(8'h10, d); check("R5 zero set keeps mask", d, 32'h5);
        wr(8'h14, 32'h1);
        rd(8'h14, d); check("R6 clear bit0", d, 32'h4);
        wr(8'h14, 32'h0);
        rd(8'h14, d); check("R6 zero clear keeps mask", d, 32'h4);
        rd(8'h60, d); check("R7 core0 after clear", d, 32'h0);
        check("R10 monitor lines", {28'd0, core_irq}, 32'h4);
        pmu_src = 4'h0;
        wr(8'h14, 32'hF);

        // R8: graphics routing
        gpu_irq_src = 1'b1; gpu_fiq_src = 1'b1;
        wr(8'h0C, 32'hE);
        rd(8'h0C, d); check("R8 routing readback", d, 32'hE);
        rd(8'h68, d); check("R8 core2 graphics IRQ", d, 32'h100);
        rd(8'h7C, d); check("R8 core3 graphics FIQ", d, 32'h100);
        rd(8'h60, d); check("R8 core0 no graphics", d, 32'h0);
        check("R8 lines", {24'd0, core_fiq, core_irq}, 32'h84);
        gpu_irq_src = 1'b0; gpu_fiq_src = 1'b0;

        // R9: mailbox pass-through
        mbox_irq[4 +: 4] = 4'h9;
        mbox_fiq[12 +: 4] = 4'h2;
        rd(8'h64, d); check("R9 core1 mailbox IRQ", d, 32'h90);
        rd(8'h7C, d); check("R9 core3 mailbox FIQ", d, 32'h20);

        // R12: status words ignore writes
        wr(8'h64, 32'hFFFF_FFFF);
        wr(8'h70, 32'hFFFF_FFFF);
        rd(8'h64, d); check("R12 core1 status unchanged", d, 32'h90);
        rd(8'h70, d); check("R12 core0 FIQ unchanged", d, 32'h0);
        rd(8'h40, d); check("R12 ctrl untouched", d, 32'h0);
        rd(8'h10, d); check("R12 mask untouched", d, 32'h0);
        mbox_irq = '0; mbox_fiq = '0;
        #1 check("R11 mailbox levels drop", {24'd0, core_fiq, core_irq}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule